// File: doc/BRIEF.md
# Event Timer with Per-Channel Comparison Width

This block is a memory-mapped event timer. It has one free-running 64-bit up-counter and one comparator channel that can raise an interrupt. Software reaches it over a simple 32-bit register bus. Through that bus it starts or halts the counter, presets the counter while it is halted, and arms the channel in one of two modes. In one-shot mode the channel fires when the counter reaches a programmed value. In periodic mode the channel adds a stored increment to its comparator on every hit.

The channel can be narrowed to a 32-bit comparison. Narrowing affects only how that channel matches and how its comparator wraps when it reloads. The shared counter always counts across all 64 bits, and carries always pass from the lower word into the upper word. Periodic setup uses a load-direct flag. With the flag set, the first comparator write sets the comparator and the second write sets the increment.

A comparator write takes two steps. A write to the upper comparator word only stages that word. A write to the lower comparator word commits the staged upper word and the written lower word together as one 64-bit value.

Top module: `evtmr_top`

## Requirements
- R1: After reset, the registers read as follows: counter = 0, global control = 0, interrupt status = 0, channel configuration = 0, comparator words = 0xFFFFFFFF. The irq output is 0.
- R2: While global control bit 0 (run) is 1, the counter rises by exactly 1 every clock. While run is 0, the counter holds its value.
- R3: Writes to the counter words (byte offsets 0x10 low, 0x14 high) take effect only while run is 0. While run is 1 they are ignored.
- R4: A carry out of the lower 32 bits always increments the upper counter word, whatever the state of the channel's narrow bit.
- R5: Bit 0 of the capability register (offset 0x00) reads 1 when the counter is 64 bits wide.
- R6: In one-shot mode (channel configuration at 0x20: enable bit 1 = 1, periodic bit 3 = 0), a cycle in which run is 1 and the counter equals the comparator sets interrupt status bit 0 (offset 0x08) at the next edge. irq follows that status bit. The comparator is left unchanged.
- R7: Writing 1 to status bit 0 clears it. Writing 0 to it has no effect.
- R8: When the load-direct bit (bit 6) is set, the first committed comparator write (a write to 0x28, using the upper word last written to 0x2C) loads the comparator. The second committed write loads the increment and clears bit 6.
- R9: In periodic mode (bit 3 = 1), each hit adds the increment to the comparator.
- R10: With the narrow bit (bit 8) set, hits compare only the low 32 bits. The comparator's upper word is ignored and is never changed by a reload, and a reload wraps within the lower 32 bits.
- R11: While run is 0, no hit occurs, even when the counter equals the comparator.
- R12: While the enable bit is 0, the interrupt status is never set.
- R13: A committed comparator write made while the load-direct bit is clear loads only the comparator. The stored increment is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Channel interrupt, high while the status bit is set |

## Verification
A wrong counter state shows up in the next read of either counter word. A lost carry shows up after only a few cycles as an upper word that stays flat, which happens if narrow mode leaks into the counter. A fault in the comparator or the increment register does not surface until the next hit. It then appears, one cycle after the counter reaches the comparator, as a status bit set at the wrong time, or as a comparator readback that moved by the wrong amount. A fault in the load-direct sequencing shows up at once in the configuration readback and the comparator readback after each commit.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

  // register byte offsets
  localparam logic [7:0] OFS_CAPS   = 8'h00;
  localparam logic [7:0] OFS_GCTRL  = 8'h04;
  localparam logic [7:0] OFS_ISTAT  = 8'h08;
  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_CHCFG  = 8'h20;
  localparam logic [7:0] OFS_CMP_LO = 8'h28;
  localparam logic [7:0] OFS_CMP_HI = 8'h2C;

  // channel configuration bit positions
  localparam int CFG_EN_BIT     = 1;
  localparam int CFG_PER_BIT    = 3;
  localparam int CFG_LOAD_BIT   = 6;
  localparam int CFG_NARROW_BIT = 8;

  // width used when a channel is narrowed
  localparam int NARROW_W = 32;

  typedef struct packed {
    logic narrow;
    logic load;
    logic periodic;
    logic en;
  } ch_cfg_t;

  typedef struct packed {
    logic gctrl;
    logic istat;
    logic cnt_lo;
    logic cnt_hi;
    logic chcfg;
    logic cmp_lo;
    logic cmp_hi;
  } wr_stb_t;

endpackage

// File: rtl/evtmr_decode.sv
module evtmr_decode
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output wr_stb_t           stb
);

  logic wr_act;
  assign wr_act = sel & wr;

  always_comb begin
    stb        = '0;
    stb.gctrl  = wr_act && (addr == ADDR_W'(OFS_GCTRL));
    stb.istat  = wr_act && (addr == ADDR_W'(OFS_ISTAT));
    stb.cnt_lo = wr_act && (addr == ADDR_W'(OFS_CNT_LO));
    stb.cnt_hi = wr_act && (addr == ADDR_W'(OFS_CNT_HI));
    stb.chcfg  = wr_act && (addr == ADDR_W'(OFS_CHCFG));
    stb.cmp_lo = wr_act && (addr == ADDR_W'(OFS_CMP_LO));
    stb.cmp_hi = wr_act && (addr == ADDR_W'(OFS_CMP_HI));
  end

endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
  parameter int CNT_W = 64,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt
);

  localparam int HI_W = CNT_W - BUS_W;

  // preset is honoured only while halted
  logic load_lo, load_hi;
  assign load_lo = wr_lo & ~run;
  assign load_hi = wr_hi & ~run;

  // full-width increment: the upper word always receives the carry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + CNT_W'(1);
    end else if (load_lo) begin
      cnt[BUS_W-1:0] <= wdata;
    end else if (load_hi) begin
      cnt[CNT_W-1:BUS_W] <= wdata[HI_W-1:0];
    end
  end

endmodule

// File: rtl/evtmr_channel.sv
module evtmr_channel
  import evtmr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_wr,
  input  logic             cmp_lo_wr,
  input  logic             cmp_hi_wr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  output ch_cfg_t          cfg,
  output logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] period,
  output logic             match_evt,
  output logic             commit
);

  localparam int HI_W = CNT_W - BUS_W;

  // equality at the active width
  function automatic logic hit_at(input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] m,
                                  input logic             nar);
    if (nar) return c[NARROW_W-1:0] == m[NARROW_W-1:0];
    return c == m;
  endfunction

  // next comparator value after a periodic hit
  function automatic logic [CNT_W-1:0] step_cmp(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] p,
                                                input logic             nar);
    logic [NARROW_W-1:0] lo_sum;
    lo_sum = c[NARROW_W-1:0] + p[NARROW_W-1:0];
    if (nar) return {c[CNT_W-1:NARROW_W], lo_sum};
    return c + p;
  endfunction

  logic [HI_W-1:0]  stage_hi;
  logic             second_pending;
  logic [CNT_W-1:0] commit_val;
  logic             to_period;
  logic             reload;

  assign commit     = cmp_lo_wr;
  assign commit_val = {stage_hi, wdata};
  assign to_period  = commit && cfg.load && second_pending;
  assign match_evt  = run && cfg.en && hit_at(cnt, cmp, cfg.narrow);
  assign reload     = match_evt && cfg.periodic;

  // configuration and load-direct sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg            <= '0;
      second_pending <= 1'b0;
    end else if (cfg_wr) begin
      cfg.en         <= wdata[CFG_EN_BIT];
      cfg.periodic   <= wdata[CFG_PER_BIT];
      cfg.load       <= wdata[CFG_LOAD_BIT];
      cfg.narrow     <= wdata[CFG_NARROW_BIT];
      second_pending <= 1'b0;
    end else if (commit && cfg.load) begin
      if (second_pending) begin
        cfg.load       <= 1'b0;
        second_pending <= 1'b0;
      end else begin
        second_pending <= 1'b1;
      end
    end
  end

  // staged upper word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_hi <= '0;
    else if (cmp_hi_wr) stage_hi <= wdata[HI_W-1:0];
  end

  // comparator: bus commit has priority over the periodic reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '1;
    end else if (commit && !to_period) begin
      cmp <= commit_val;
    end else if (reload) begin
      cmp <= step_cmp(cmp, period, cfg.narrow);
    end
  end

  // increment register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period <= '0;
    else if (to_period) period <= commit_val;
  end

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam logic WIDE_CNT = (CNT_W == 64);

  wr_stb_t          stb;
  logic             run_q;
  logic             istat_q;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0] period_w;
  ch_cfg_t          ch_cfg;
  logic             match_evt;
  logic             cmp_commit;
  logic             cnt_wr_req;
  logic [BUS_W-1:0] cfg_rd;

  evtmr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .sel (bus_sel),
    .wr  (bus_wr),
    .addr(bus_addr),
    .stb (stb)
  );

  evtmr_counter #(.CNT_W(CNT_W), .BUS_W(BUS_W)) cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .wr_lo(stb.cnt_lo),
    .wr_hi(stb.cnt_hi),
    .wdata(bus_wdata),
    .cnt  (cnt_w)
  );

  evtmr_channel #(.CNT_W(CNT_W), .BUS_W(BUS_W)) ch_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .cfg_wr   (stb.chcfg),
    .cmp_lo_wr(stb.cmp_lo),
    .cmp_hi_wr(stb.cmp_hi),
    .wdata    (bus_wdata),
    .cnt      (cnt_w),
    .cfg      (ch_cfg),
    .cmp      (cmp_w),
    .period   (period_w),
    .match_evt(match_evt),
    .commit   (cmp_commit)
  );

  assign cnt_wr_req = stb.cnt_lo | stb.cnt_hi;

  // global run control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else if (stb.gctrl) run_q <= bus_wdata[0];
  end

  // interrupt status: a hit wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) istat_q <= 1'b0;
    else if (match_evt) istat_q <= 1'b1;
    else if (stb.istat && bus_wdata[0]) istat_q <= 1'b0;
  end

  assign irq = istat_q;

  always_comb begin
    cfg_rd                 = '0;
    cfg_rd[CFG_EN_BIT]     = ch_cfg.en;
    cfg_rd[CFG_PER_BIT]    = ch_cfg.periodic;
    cfg_rd[CFG_LOAD_BIT]   = ch_cfg.load;
    cfg_rd[CFG_NARROW_BIT] = ch_cfg.narrow;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_CAPS):   bus_rdata[0] = WIDE_CNT;
      ADDR_W'(OFS_GCTRL):  bus_rdata[0] = run_q;
      ADDR_W'(OFS_ISTAT):  bus_rdata[0] = istat_q;
      ADDR_W'(OFS_CNT_LO): bus_rdata = cnt_w[BUS_W-1:0];
      ADDR_W'(OFS_CNT_HI): bus_rdata = cnt_w[CNT_W-1:BUS_W];
      ADDR_W'(OFS_CHCFG):  bus_rdata = cfg_rd;
      ADDR_W'(OFS_CMP_LO): bus_rdata = cmp_w[BUS_W-1:0];
      ADDR_W'(OFS_CMP_HI): bus_rdata = cmp_w[CNT_W-1:BUS_W];
      default:             bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evtmr_chk.sv
module evtmr_chk
  import evtmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_wr_req,
  input logic             match_evt,
  input logic             istat,
  input ch_cfg_t          cfg,
  input logic [CNT_W-1:0] cmp,
  input logic [CNT_W-1:0] period,
  input logic             commit
);

  // R2 and R4: full-width step while running
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + CNT_W'(1));

  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr_req) |=> $stable(cnt));

  assert_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_wr_req) |=> cnt == $past(cnt) + CNT_W'(1));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> istat);

  assert_oneshot_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cfg.periodic && !commit) |=> $stable(cmp));

  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && cfg.periodic && !cfg.narrow && !commit)
      |=> cmp == $past(cmp) + $past(period));

  assert_upper_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && cfg.periodic && cfg.narrow && !commit)
      |=> cmp[CNT_W-1:NARROW_W] == $past(cmp[CNT_W-1:NARROW_W]));

  assert_quiet_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !istat) |=> !istat);

  assert_quiet_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en && !istat) |=> !istat);

endmodule

bind evtmr_top evtmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run_q),
  .cnt       (cnt_w),
  .cnt_wr_req(cnt_wr_req),
  .match_evt (match_evt),
  .istat     (istat_q),
  .cfg       (ch_cfg),
  .cmp       (cmp_w),
  .period    (period_w),
  .commit    (cmp_commit)
);

// File: tb/evtmr_top_tb_top.sv
module evtmr_top_tb_top;

  localparam logic [7:0] A_CAPS   = 8'h00;
  localparam logic [7:0] A_GCTRL  = 8'h04;
  localparam logic [7:0] A_ISTAT  = 8'h08;
  localparam logic [7:0] A_CNT_LO = 8'h10;
  localparam logic [7:0] A_CNT_HI = 8'h14;
  localparam logic [7:0] A_CHCFG  = 8'h20;
  localparam logic [7:0] A_CMP_LO = 8'h28;
  localparam logic [7:0] A_CMP_HI = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] e;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  rd_go;

  // 4 time-unit period (250 MHz with 1 ns units)
  always #2 clk = ~clk;

  evtmr_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: pops expected reads and compares mid-cycle
  initial begin
    forever begin
      item_t it;
      @(rd_go);
      #1;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.e) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, bus_rdata, it.e);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.a = a; it.e = e; it.tag = tag;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    sb_q.push_back(it);
    -> rd_go;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  // counter advances by k+1 over this call
  task automatic run_for(input int k);
    bus_write(A_GCTRL, 32'h1);
    repeat (k) @(negedge clk);
    bus_write(A_GCTRL, 32'h0);
  endtask

  task automatic set_cnt(input logic [31:0] hi, input logic [31:0] lo);
    bus_write(A_CNT_HI, hi);
    bus_write(A_CNT_LO, lo);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R5 reset state
    expect_rd(A_CAPS,   32'h1,        "R5 wide-counter capability");
    expect_rd(A_GCTRL,  32'h0,        "R1 gctrl reset");
    expect_rd(A_ISTAT,  32'h0,        "R1 status reset");
    expect_rd(A_CNT_LO, 32'h0,        "R1 counter lo reset");
    expect_rd(A_CNT_HI, 32'h0,        "R1 counter hi reset");
    expect_rd(A_CHCFG,  32'h0,        "R1 chcfg reset");
    expect_rd(A_CMP_LO, 32'hFFFFFFFF, "R1 cmp lo reset");
    expect_rd(A_CMP_HI, 32'hFFFFFFFF, "R1 cmp hi reset");
    expect_irq(1'b0, "R1 irq reset");

    // R2 counting and holding
    run_for(9);
    expect_rd(A_CNT_LO, 32'd10, "R2 counted ten");
    repeat (5) @(negedge clk);
    expect_rd(A_CNT_LO, 32'd10, "R2 halted hold");

    // R3 preset only while halted
    set_cnt(32'h0, 32'h0);
    expect_rd(A_CNT_LO, 32'h0, "R3 halted preset");
    bus_write(A_GCTRL, 32'h1);
    bus_write(A_CNT_LO, 32'h1234);
    bus_write(A_GCTRL, 32'h0);
    expect_rd(A_CNT_LO, 32'd2, "R3 write ignored while running");

    // R4 carry with narrow bit set
    bus_write(A_CHCFG, 32'h100);
    set_cnt(32'h0, 32'hFFFFFFFE);
    run_for(3);
    expect_rd(A_CNT_HI, 32'h1, "R4 carry into upper word");
    expect_rd(A_CNT_LO, 32'h2, "R4 lower word after carry");

    // R12 channel disabled
    bus_write(A_CHCFG, 32'h0);
    bus_write(A_CMP_HI, 32'h0);
    bus_write(A_CMP_LO, 32'h20);
    set_cnt(32'h0, 32'h0);
    run_for(32'h30);
    expect_rd(A_ISTAT, 32'h0, "R12 no status while disabled");
    expect_irq(1'b0, "R12 irq low while disabled");

    // R11 then R6 one-shot
    bus_write(A_CHCFG, 32'h2);
    set_cnt(32'h0, 32'h0);
    run_for(32'h1F);
    expect_rd(A_CNT_LO, 32'h20, "R11 counter parked on comparator");
    expect_rd(A_ISTAT, 32'h0, "R11 no hit while halted");
    run_for(4);
    expect_rd(A_ISTAT, 32'h1, "R6 one-shot hit");
    expect_irq(1'b1, "R6 irq follows status");
    expect_rd(A_CMP_LO, 32'h20, "R6 comparator unchanged");

    // R7 write-one-to-clear
    bus_write(A_ISTAT, 32'h0);
    expect_rd(A_ISTAT, 32'h1, "R7 zero write no effect");
    bus_write(A_ISTAT, 32'h1);
    expect_rd(A_ISTAT, 32'h0, "R7 one write clears");
    expect_irq(1'b0, "R7 irq cleared");

    // R8 load-direct sequence
    bus_write(A_CHCFG, 32'h4A);
    expect_rd(A_CHCFG, 32'h4A, "R8 config readback");
    bus_write(A_CMP_HI, 32'h0);
    bus_write(A_CMP_LO, 32'h10);
    expect_rd(A_CMP_LO, 32'h10, "R8 first commit loads comparator");
    expect_rd(A_CHCFG, 32'h4A, "R8 load bit held after first commit");
    bus_write(A_CMP_LO, 32'h08);
    expect_rd(A_CHCFG, 32'h0A, "R8 load bit self-clears");
    expect_rd(A_CMP_LO, 32'h10, "R8 second commit not in comparator");

    // R9 periodic reload: hits at 0x10, 0x18, 0x20
    set_cnt(32'h0, 32'h0);
    run_for(32'h20);
    expect_rd(A_CMP_LO, 32'h28, "R9 comparator advanced three times");
    expect_rd(A_CMP_HI, 32'h0, "R9 comparator upper word");
    expect_rd(A_ISTAT, 32'h1, "R9 status set");
    bus_write(A_ISTAT, 32'h1);

    // R13 plain commit keeps the increment
    bus_write(A_CMP_HI, 32'h0);
    bus_write(A_CMP_LO, 32'h30);
    expect_rd(A_CMP_LO, 32'h30, "R13 plain commit loads comparator");
    set_cnt(32'h0, 32'h2E);
    run_for(3);
    expect_rd(A_CMP_LO, 32'h38, "R13 increment retained");
    bus_write(A_ISTAT, 32'h1);

    // R10 narrow periodic with wrap, R4 carry alongside
    bus_write(A_CHCFG, 32'h14A);
    set_cnt(32'h7, 32'hFFFFFFF0);
    bus_write(A_CMP_HI, 32'h5);
    bus_write(A_CMP_LO, 32'hFFFFFFF8);
    bus_write(A_CMP_LO, 32'h10);
    run_for(32'hF);
    expect_rd(A_ISTAT, 32'h1, "R10 low-word hit despite upper mismatch");
    expect_rd(A_CMP_LO, 32'h8, "R10 reload wraps in 32 bits");
    expect_rd(A_CMP_HI, 32'h5, "R10 upper word untouched");
    expect_rd(A_CNT_HI, 32'h8, "R4 counter upper word not truncated");
    expect_rd(A_CNT_LO, 32'h0, "R4 counter lower word");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule